// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block gives a host access to a bank of byte-wide control registers over a three-wire serial port. The port has a serial clock, an active-low select and one data line that both sides share. All port inputs are brought into the block's own system clock. The block finds the serial clock edges by oversampling, so it needs no second clock domain.

Every transfer starts with a two-byte instruction, sent most significant bit first. The instruction gives the direction, a two-bit burst code and a 13-bit register address. One or more data bytes follow. On a write the host drives the data line for each byte, and the byte is stored once its eighth bit has arrived. On a read the block takes over the data line and shifts out register contents. Either way the address counts down by one after each byte. The 13-bit address is kept in full, but only its low bits select a storage cell, so the space aliases onto a smaller array.

Top module: `spi3_reg_slave`

## Requirements
- R1: While select is high, the output enable stays low, the data output stays low and the transfer state machine is returned to its start.
- R2: Bit 7 of the first instruction byte selects the direction (1 = read, 0 = write). Bits 4..0 of that byte carry address bits 12..8, and the second byte carries address bits 7..0. All bits are sent most significant first.
- R3: Bits 6..5 of the first instruction byte set the burst length: 00 = one data byte, 01 = two, 10 = three. Bytes clocked after the burst are ignored: they are not written, and they are not driven on a read.
- R4: Burst code 11 keeps transferring data bytes until select rises.
- R5: After each data byte the address decreases by one, and it wraps from 0x0000 to 0x1FFF.
- R6: A written byte is stored only after all 8 of its bits have been sampled. A byte cut short by select rising is discarded.
- R7: During the data phase of a read the block asserts the output enable, and it launches each bit on a falling serial clock edge, so the bit is valid at the next rising edge. The output enable is never asserted during a write.
- R8: Select going low starts a fresh decode, even when the previous transfer was cut off part way through.
- R9: The register file holds DEPTH bytes, indexed by the low log2(DEPTH) address bits, and is cleared to 0x00 by reset.
- R10: Input bits are taken at the rising serial clock edge. Changes on the data line while the serial clock is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 6x the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low transfer select |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side |
| sdio_oe | output | 1 | High when the block drives the shared data line |

## Verification
On every cycle the assertions check the following: the port is quiet and the state is cleared while select is high, the output enable appears only for reads, the address steps down after each data byte, only a bounded burst can reach its final state, and each store lands in the addressed cell. The behaviours that need whole transfers are shown only by the bench scenarios. These are burst lengths and the bytes ignored after a burst, streaming, wrap-around and aliasing of the address, and the dropping of partial bytes. They also include recovery after a cut-off instruction and the ignoring of data-line changes while the clock is high.

// File: rtl/spi3_pkg.sv
// Shared definitions for the three-wire register slave.
// Assumes: the address is at least 9 bits wide and at most 13 bits wide.
package spi3_pkg;

    // Position within one transfer
    typedef enum logic [1:0] {
        PH_CMD_HI = 2'd0,   // first instruction byte
        PH_CMD_LO = 2'd1,   // second instruction byte
        PH_DATA   = 2'd2,   // data bytes
        PH_DONE   = 2'd3    // bounded burst finished, ignore the rest
    } phase_e;

    localparam logic [1:0] BURST_STREAM = 2'b11;

    // Number of data bytes for a bounded burst code (00 -> 1, 01 -> 2, 10 -> 3)
    function automatic logic [1:0] burst_bytes(input logic [1:0] code);
        return code + 2'd1;
    endfunction

endpackage

// File: rtl/spi3_sync_edge.sv
// Brings sclk, cs_n and sdio_i into the clk domain and flags serial clock edges.
// Assumes: each sclk level lasts at least three clk cycles. All three inputs
// pass through the same number of stages, so data and clock stay aligned.
module spi3_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdio_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_idle,
    output logic sdio_s
);
    localparam int SIG_W = 3;
    localparam logic [SIG_W-1:0] IDLE_VAL = 3'b010; // {sdio, cs_n, sclk}

    logic [SIG_W-1:0] pipe_q [STAGES];
    logic             sclk_prev_q;

    // Synchroniser chain, one stage per generate step
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage captures the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[0] <= IDLE_VAL;
                else        pipe_q[0] <= {sdio_i, cs_n, sclk};
            end
        end else begin : g_next
            // later stages shift the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q[s] <= IDLE_VAL;
                else        pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    // Remember the previous synchronised clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= pipe_q[STAGES-1][0];
    end

    assign sclk_rise = pipe_q[STAGES-1][0] & ~sclk_prev_q;
    assign sclk_fall = ~pipe_q[STAGES-1][0] & sclk_prev_q;
    assign cs_idle   = pipe_q[STAGES-1][1];
    assign sdio_s    = pipe_q[STAGES-1][2];

endmodule

// File: rtl/spi3_frame_ctrl.sv
// Decodes the instruction, sequences data bytes, moves the address and drives
// the shared data line during reads.
// Assumes: inputs are already synchronised, and the edge flags last one cycle.
module spi3_frame_ctrl
    import spi3_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int IDX_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_idle,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             sdio_s,
    input  logic [7:0]       rd_byte,
    output logic [IDX_W-1:0] reg_idx,
    output logic             wr_en,
    output logic [7:0]       wr_byte,
    output logic             sdio_o,
    output logic             sdio_oe
);
    localparam int HI_W = ADDR_W - 8;

    phase_e            phase_q;
    logic [2:0]        bit_cnt_q;
    logic [6:0]        shreg_q;
    logic              rw_q;
    logic              stream_q;
    logic [1:0]        left_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        byte_in;
    logic              byte_end;

    assign byte_in  = {shreg_q, sdio_s};
    assign byte_end = sclk_rise && !cs_idle && (bit_cnt_q == 3'd7);
    assign wr_en    = byte_end && (phase_q == PH_DATA) && !rw_q;
    assign wr_byte  = byte_in;
    assign reg_idx  = addr_q[IDX_W-1:0];

    // Sample input bits on rising edges and advance the transfer phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_CMD_HI;
            bit_cnt_q <= 3'd0;
            shreg_q   <= 7'd0;
            rw_q      <= 1'b0;
            stream_q  <= 1'b0;
            left_q    <= 2'd0;
            addr_q    <= '0;
        end else if (cs_idle) begin
            phase_q   <= PH_CMD_HI;
            bit_cnt_q <= 3'd0;
            shreg_q   <= 7'd0;
        end else if (sclk_rise) begin
            shreg_q   <= byte_in[6:0];
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
                case (phase_q)
                    PH_CMD_HI: begin
                        rw_q                 <= byte_in[7];
                        stream_q             <= (byte_in[6:5] == BURST_STREAM);
                        left_q               <= burst_bytes(byte_in[6:5]);
                        addr_q[ADDR_W-1:8]   <= byte_in[HI_W-1:0];
                        phase_q              <= PH_CMD_LO;
                    end
                    PH_CMD_LO: begin
                        addr_q[7:0] <= byte_in;
                        phase_q     <= PH_DATA;
                    end
                    PH_DATA: begin
                        addr_q <= addr_q - 1'b1;
                        left_q <= left_q - 2'd1;
                        if (!stream_q && left_q == 2'd1) phase_q <= PH_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Launch read bits on falling edges and own the line only during a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdio_oe <= 1'b0;
            sdio_o  <= 1'b0;
        end else if (cs_idle) begin
            sdio_oe <= 1'b0;
            sdio_o  <= 1'b0;
        end else if (sclk_fall) begin
            if (phase_q == PH_DATA && rw_q) begin
                sdio_oe <= 1'b1;
                sdio_o  <= rd_byte[3'd7 - bit_cnt_q];
            end else begin
                sdio_oe <= 1'b0;
                sdio_o  <= 1'b0;
            end
        end
    end

    // R1: select high leaves the port quiet and the sequencer at its start
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> (!sdio_oe && !sdio_o && bit_cnt_q == 3'd0 && phase_q == PH_CMD_HI));

    // R7: the line is only driven for a read transfer
    p_oe_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> rw_q);

    // R5: every completed data byte moves the address down by one
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && phase_q == PH_DATA) |=> (addr_q == $past(addr_q) - 1'b1));

    // R3: only a bounded burst can reach the finished state
    p_done_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DONE) |-> !stream_q);

endmodule

// File: rtl/spi3_regfile.sv
// Byte-wide register storage with one write port and one asynchronous read port.
// Assumes: one index serves both ports, and reset clears every cell.
module spi3_regfile #(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);
    logic [7:0] mem_q [DEPTH];

    // Clear on reset, store a completed byte when asked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rdata = mem_q[idx];

    // R6: a store request lands in the addressed cell
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/spi3_reg_slave.sv
// Top level of the three-wire register slave: synchroniser, frame controller
// and register file.
// Assumes: the host keeps each sclk level for at least three clk cycles and
// releases the shared line whenever sdio_oe is high.
module spi3_reg_slave #(
    parameter int ADDR_W      = 13,
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdio_i,
    output logic sdio_o,
    output logic sdio_oe
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             sclk_rise, sclk_fall, cs_idle, sdio_s;
    logic [IDX_W-1:0] reg_idx;
    logic             wr_en;
    logic [7:0]       wr_byte, rd_byte;

    spi3_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_i(sdio_i),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_idle(cs_idle), .sdio_s(sdio_s)
    );

    spi3_frame_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .sdio_s(sdio_s), .rd_byte(rd_byte),
        .reg_idx(reg_idx), .wr_en(wr_en), .wr_byte(wr_byte),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe)
    );

    spi3_regfile #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .idx(reg_idx),
        .wdata(wr_byte), .rdata(rd_byte)
    );

endmodule

// File: tb/spi3_reg_slave_tb.sv
// Directed bench for the three-wire register slave, with one task per scenario.
module spi3_reg_slave_tb;
    localparam int HALF = 6;   // clk cycles per serial clock half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdio_i = 1'b0;
    logic sdio_o, sdio_oe;
    int   n_checks = 0;
    int   n_fail = 0;
    logic wr_oe_seen = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    spi3_reg_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // host drives one bit, then scrambles the line while sclk is high (R10)
    task automatic bit_out(input logic b);
        sdio_i = b;
        repeat (HALF) @(negedge clk);
        if (sdio_oe) wr_oe_seen = 1'b1;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sdio_i = ~b;
        repeat (HALF - 2) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic bit_in(output logic b, output logic oe);
        sdio_i = 1'b0;
        repeat (HALF) @(negedge clk);
        b  = sdio_o;
        oe = sdio_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic recv_byte(output logic [7:0] v, output logic oe_all, output logic oe_any);
        logic b, oe;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b, oe);
            v[i]   = b;
            oe_all = oe_all & oe;
            oe_any = oe_any | oe;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        sdio_i = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic instr(input logic rd, input logic [1:0] w, input logic [12:0] a);
        send_byte({rd, w, a[12:8]});
        send_byte(a[7:0]);
    endtask

    task automatic wr1(input logic [12:0] a, input logic [7:0] v);
        cs_begin(); instr(1'b0, 2'b00, a); send_byte(v); cs_end();
    endtask

    task automatic rd1(input logic [12:0] a, output logic [7:0] v, output logic oe_all);
        logic any;
        cs_begin(); instr(1'b1, 2'b00, a); recv_byte(v, oe_all, any); cs_end();
    endtask

    task automatic t_reset();
        logic [7:0] v; logic oe;
        check(sdio_oe == 1'b0, "R1 reset oe", sdio_oe, 0);
        check(sdio_o == 1'b0, "R1 reset out", sdio_o, 0);
        rd1(13'h0000, v, oe);
        check(v == 8'h00, "R9 reset contents", v, 0);
        check(sdio_oe == 1'b0, "R1 oe after select high", sdio_oe, 0);
    endtask

    task automatic t_single();
        logic [7:0] v; logic oe;
        wr_oe_seen = 1'b0;
        wr1(13'h0005, 8'hA5);
        check(wr_oe_seen == 1'b0, "R7 no drive during write", wr_oe_seen, 0);
        rd1(13'h0005, v, oe);
        check(v == 8'hA5, "R2 single write/read", v, 8'hA5);
        check(oe == 1'b1, "R7 oe across read byte", oe, 1);
        rd1(13'h0005, v, oe);
        check(v == 8'hA5, "R2 read does not alter register", v, 8'hA5);
    endtask

    task automatic t_burst3();
        logic [7:0] v, v2, v3; logic oe, any;
        cs_begin(); instr(1'b0, 2'b10, 13'h0012);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); cs_end();
        rd1(13'h0011, v, oe);
        check(v == 8'h22, "R5 second byte at address-1", v, 8'h22);
        rd1(13'h0010, v, oe);
        check(v == 8'h33, "R3 three-byte burst third byte", v, 8'h33);
        cs_begin(); instr(1'b1, 2'b10, 13'h0012);
        recv_byte(v, oe, any); recv_byte(v2, oe, any); recv_byte(v3, oe, any); cs_end();
        check({v, v2, v3} == 24'h112233, "R5 burst read descending", {v, v2, v3}, 24'h112233);
    endtask

    task automatic t_burst2_extra();
        logic [7:0] v; logic oe, any;
        cs_begin(); instr(1'b0, 2'b01, 13'h0020);
        send_byte(8'h44); send_byte(8'h55); send_byte(8'h66); cs_end();
        rd1(13'h001F, v, oe);
        check(v == 8'h55, "R3 two-byte burst second byte", v, 8'h55);
        rd1(13'h001E, v, oe);
        check(v == 8'h00, "R3 byte beyond burst not written", v, 0);
        cs_begin(); instr(1'b1, 2'b00, 13'h0020);
        recv_byte(v, oe, any);
        check(v == 8'h44, "R3 one-byte read", v, 8'h44);
        recv_byte(v, oe, any); cs_end();
        check(any == 1'b0, "R3 no drive beyond read burst", any, 0);
    endtask

    task automatic t_stream();
        logic [7:0] v; logic oe, any; bit ok = 1;
        cs_begin(); instr(1'b0, 2'b11, 13'h0030);
        for (int i = 0; i < 5; i++) send_byte(8'hC0 + 8'(i));
        cs_end();
        cs_begin(); instr(1'b1, 2'b11, 13'h0030);
        for (int i = 0; i < 5; i++) begin
            recv_byte(v, oe, any);
            if (v != 8'hC0 + 8'(i) || !oe) ok = 0;
        end
        cs_end();
        check(ok, "R4 five-byte stream write/read", ok, 1);
        rd1(13'h002C, v, oe);
        check(v == 8'hC4, "R4 last streamed byte", v, 8'hC4);
    endtask

    task automatic t_wrap();
        logic [7:0] v; logic oe;
        cs_begin(); instr(1'b0, 2'b01, 13'h0000);
        send_byte(8'h77); send_byte(8'h88); cs_end();
        rd1(13'h1FFF, v, oe);
        check(v == 8'h88, "R5 wrap 0x0000 to 0x1FFF", v, 8'h88);
        rd1(13'h003F, v, oe);
        check(v == 8'h88, "R9 aliasing by low index bits", v, 8'h88);
        rd1(13'h1105, v, oe);
        check(v == 8'hA5, "R9 high address bits ignored for index", v, 8'hA5);
    endtask

    task automatic t_partial();
        logic [7:0] v; logic oe;
        cs_begin(); instr(1'b0, 2'b00, 13'h0008);
        for (int i = 0; i < 5; i++) bit_out(1'b1);
        cs_end();
        rd1(13'h0008, v, oe);
        check(v == 8'h00, "R6 partial byte discarded", v, 0);
        cs_begin(); send_byte(8'h00);
        for (int i = 0; i < 3; i++) bit_out(1'b1);
        cs_end();
        wr1(13'h0009, 8'h3C);
        rd1(13'h0009, v, oe);
        check(v == 8'h3C, "R8 fresh decode after cut instruction", v, 8'h3C);
    endtask

    task automatic t_edge();
        logic [7:0] v; logic oe;
        wr1(13'h0015, 8'h5A);
        rd1(13'h0015, v, oe);
        check(v == 8'h5A, "R10 high-phase line changes ignored", v, 8'h5A);
        check(sdio_oe == 1'b0, "R1 released after read", sdio_oe, 0);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_single();
        t_burst3();
        t_burst2_extra();
        t_stream();
        t_wrap();
        t_partial();
        t_edge();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule